// File: doc/BRIEF.md
# Multi-channel input capture unit

This block timestamps edges on a group of input pins. A free-running counter comes in from elsewhere in the chip and is shared by all channels. Each channel watches one pin, and each pin first passes through a synchronizer clocked by the bus clock. When the edge type chosen for a channel appears, the block copies the counter value into that channel's capture register and raises a sticky event flag. The flag, gated by a per-channel enable, drives an active-high interrupt line.

Software reaches the block over a simple word bus with byte addresses. Address bit 0 is ignored, and every access moves one full word in a single cycle. Flags are cleared by writing ones to them. In the optional fast-clear mode, reading a channel's capture register also clears that channel's flag. A per-channel hold bit parks a channel outside capture mode. While held, the channel does not capture, and the bus can load its capture register.

Top module: `icu_capture_top`

## Requirements
- R1: The edge code of channel n sits in bits [2n+1:2n] of the edge register at byte address 0x02. Code 00 disables capture, 01 captures rising edges only, 10 captures falling edges only, and 11 captures both.
- R2: A pin level first sampled at clock edge k is captured at clock edge k+2. The capture register takes the value present on `cnt_i` at edge k+2.
- R3: Every capture sets the channel's flag, which reads back as bit n of the flag register at byte address 0x06.
- R4: A write to the flag register clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: When bit 0 of the control register at 0x08 is 1, a read of the capture register of channel n (at 0x10 + 2n) clears flag n. When that bit is 0, reads leave the flags unchanged.
- R6: If a capture and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_o[n]` is 1 exactly when flag n is set and bit n of the enable register at 0x04 is 1.
- R8: Bit n of the hold register at 0x00 set to 0 puts channel n in capture mode, and bus writes to its capture register are then ignored. Set to 1, it stops captures on channel n and lets bus writes load the capture register.
- R9: After reset, every register reads 0. Reads are combinational and return the hold, edge, enable, flag, control and capture registers at their word addresses; address bit 0 is ignored and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Shared free-running counter value |
| pin_i | input | NCH | Asynchronous capture pins, one per channel |
| bus_addr | input | AW | Byte address; bit 0 ignored |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, used for fast clear |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational on bus_addr |
| irq_o | output | NCH | Per-channel interrupt requests, active high |

## Verification
The hardest case to produce is a capture and a flag clear landing on the same clock edge. The edge only takes effect two synchronizer stages after the pin moves. The bench toggles a pin and then issues the write-one-to-clear exactly two cycles later, so both reach the flag on the same edge. Fast-clear reads that race a capture arise the same way during a randomized phase. In that phase a behavioural model tracks pin history, captures and clears cycle by cycle.

// File: rtl/icu_pkg.sv
package icu_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   // byte offsets of the register words
   localparam int OFS_HOLD = 'h00;
   localparam int OFS_EDGE = 'h02;
   localparam int OFS_IEN  = 'h04;
   localparam int OFS_FLAG = 'h06;
   localparam int OFS_CTRL = 'h08;
   localparam int OFS_CAP0 = 'h10;

   function automatic logic edge_match(edge_sel_e sel, logic rise, logic fall);
      case (sel)
         EDGE_RISE: return rise;
         EDGE_FALL: return fall;
         EDGE_ANY:  return rise | fall;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/icu_edge_det.sv
module icu_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("icu_edge_det: SYNC_STAGES must be at least 2");
   end

   // bits [SYNC_STAGES-1:0] synchronize, the top bit holds the previous sample
   logic [SYNC_STAGES:0] pipe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], pin_i};
   end

   logic lvl_now, lvl_prev;
   assign lvl_now  = pipe_q[SYNC_STAGES-1];
   assign lvl_prev = pipe_q[SYNC_STAGES];
   assign rise_o   =  lvl_now & ~lvl_prev;
   assign fall_o   = ~lvl_now &  lvl_prev;

   AST_RISE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> $past(pipe_q[SYNC_STAGES-2])) else $error("rise without sampled high"); // R2

endmodule

// File: rtl/icu_chan.sv
module icu_chan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_i,
   input  logic          hit_i,
   input  logic          hold_i,
   input  logic          wr_i,
   input  logic [CW-1:0] wdata_i,
   input  logic          clr_i,
   output logic [CW-1:0] cap_o,
   output logic          flag_o
);

   logic fire;
   assign fire = hit_i & ~hold_i;

   always_ff @(posedge clk) begin
      if (!rst_n)               cap_o <= '0;
      else if (fire)            cap_o <= cnt_i;
      else if (wr_i && hold_i)  cap_o <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (fire)  flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cap_o == $past(cnt_i))) else $error("capture value wrong"); // R2
   AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> flag_o) else $error("capture did not flag"); // R3
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !fire) |=> !flag_o) else $error("clear ignored"); // R4
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && fire) |=> flag_o) else $error("clear beat set"); // R6
   AST_CAPMODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !hit_i) |=> $stable(cap_o)) else $error("capture reg moved"); // R8

endmodule

// File: rtl/icu_capture_top.sv
module icu_capture_top
   import icu_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int CW          = 16,
   parameter int DW          = 16,
   parameter int AW          = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_i,
   input  logic [NCH-1:0] pin_i,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [NCH-1:0] irq_o
);

   localparam int WIW      = AW - 1;
   localparam int IDX_HOLD = OFS_HOLD / 2;
   localparam int IDX_EDGE = OFS_EDGE / 2;
   localparam int IDX_IEN  = OFS_IEN  / 2;
   localparam int IDX_FLAG = OFS_FLAG / 2;
   localparam int IDX_CTRL = OFS_CTRL / 2;
   localparam int IDX_CAP0 = OFS_CAP0 / 2;

   if (NCH < 1 || 2 * NCH > DW) begin : g_bad_nch
      $error("icu_capture_top: edge codes of NCH channels must fit one word");
   end
   if (CW > DW) begin : g_bad_cw
      $error("icu_capture_top: counter wider than the bus word");
   end
   if (OFS_CAP0 + 2 * NCH > (1 << AW)) begin : g_bad_aw
      $error("icu_capture_top: AW too small for the capture registers");
   end

   logic [WIW-1:0]   widx;
   logic [NCH-1:0]   hold_q, ien_q, flag_v;
   logic [2*NCH-1:0] edge_q;
   logic             fast_q;
   logic [CW-1:0]    cap_arr [NCH];
   logic             unused_bits;

   assign widx        = bus_addr[AW-1:1];
   assign unused_bits = ^{bus_addr[0], bus_wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         edge_q <= '0;
         ien_q  <= '0;
         fast_q <= 1'b0;
      end else if (bus_wr) begin
         if (widx == WIW'(IDX_HOLD)) hold_q <= bus_wdata[NCH-1:0];
         if (widx == WIW'(IDX_EDGE)) edge_q <= bus_wdata[2*NCH-1:0];
         if (widx == WIW'(IDX_IEN))  ien_q  <= bus_wdata[NCH-1:0];
         if (widx == WIW'(IDX_CTRL)) fast_q <= bus_wdata[0];
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic rise, fall, hit, sel, clr;

      icu_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[n]),
         .rise_o (rise),
         .fall_o (fall)
      );

      assign hit = edge_match(edge_sel_e'(edge_q[2*n +: 2]), rise, fall);
      assign sel = (widx == WIW'(IDX_CAP0 + n));
      assign clr = (bus_wr && widx == WIW'(IDX_FLAG) && bus_wdata[n])
                 || (bus_rd && fast_q && sel);

      icu_chan #(.CW(CW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .cnt_i   (cnt_i),
         .hit_i   (hit),
         .hold_i  (hold_q[n]),
         .wr_i    (bus_wr && sel),
         .wdata_i (bus_wdata[CW-1:0]),
         .clr_i   (clr),
         .cap_o   (cap_arr[n]),
         .flag_o  (flag_v[n])
      );

      assign irq_o[n] = flag_v[n] & ien_q[n];

      AST_FAST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && fast_q && sel && !hit) |=> !flag_v[n]) else $error("fast clear missed"); // R5
      AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && widx == WIW'(IDX_IEN) && !bus_wdata[n]) |=> !irq_o[n]) else $error("irq while disabled"); // R7
   end

   always_comb begin
      bus_rdata = '0;
      if (widx == WIW'(IDX_HOLD)) bus_rdata[NCH-1:0]   = hold_q;
      if (widx == WIW'(IDX_EDGE)) bus_rdata[2*NCH-1:0] = edge_q;
      if (widx == WIW'(IDX_IEN))  bus_rdata[NCH-1:0]   = ien_q;
      if (widx == WIW'(IDX_FLAG)) bus_rdata[NCH-1:0]   = flag_v;
      if (widx == WIW'(IDX_CTRL)) bus_rdata[0]         = fast_q;
      for (int n = 0; n < NCH; n++) begin
         if (widx == WIW'(IDX_CAP0 + n)) bus_rdata = DW'(cap_arr[n]);
      end
   end

endmodule

// File: tb/icu_capture_top_tb_top.sv
module icu_capture_top_tb_top;
   localparam int NCH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_i = 16'h0100;
   logic [7:0]  pin_i = '0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  irq_o;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;
   always @(negedge clk) cnt_i <= cnt_i + 16'd1;

   icu_capture_top dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .pin_i(pin_i),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // behavioural reference model
   int          m_s1 [NCH], m_s2 [NCH], m_pv [NCH];
   logic [15:0] m_cap [NCH];
   logic [7:0]  m_flag, m_hold, m_ien, setv, clrv;
   logic [15:0] m_edge;
   logic        m_fast;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < NCH; n++) begin
            m_s1[n] = 0; m_s2[n] = 0; m_pv[n] = 0; m_cap[n] = 0;
         end
         m_flag = 0; m_hold = 0; m_ien = 0; m_edge = 0; m_fast = 0;
      end else begin
         int wi;
         wi = int'(bus_addr) / 2;
         setv = 0;
         clrv = 0;
         for (int n = 0; n < NCH; n++) begin
            bit r, f, h;
            int code;
            r = (m_s2[n] == 1) && (m_pv[n] == 0);
            f = (m_s2[n] == 0) && (m_pv[n] == 1);
            code = int'(m_edge[2*n +: 2]);
            h = (code == 1 && r) || (code == 2 && f) || (code == 3 && (r || f));
            if (h && !m_hold[n]) begin
               m_cap[n] = cnt_i;
               setv[n] = 1'b1;
            end
         end
         if (bus_wr && wi == 3) clrv = bus_wdata[7:0];
         if (bus_rd && m_fast && wi >= 8 && wi < 8 + NCH) clrv[wi-8] = 1'b1;
         if (bus_wr && wi >= 8 && wi < 8 + NCH && m_hold[wi-8]) m_cap[wi-8] = bus_wdata;
         if (bus_wr && wi == 0) m_hold = bus_wdata[7:0];
         if (bus_wr && wi == 1) m_edge = bus_wdata;
         if (bus_wr && wi == 2) m_ien  = bus_wdata[7:0];
         if (bus_wr && wi == 4) m_fast = bus_wdata[0];
         m_flag = (m_flag & ~clrv) | setv;
         for (int n = 0; n < NCH; n++) begin
            m_pv[n] = m_s2[n];
            m_s2[n] = m_s1[n];
            m_s1[n] = int'(pin_i[n]);
         end
      end
   end

   function automatic logic [15:0] m_read(input logic [5:0] a);
      int wi;
      wi = int'(a) / 2;
      if (wi == 0) return {8'h0, m_hold};
      if (wi == 1) return m_edge;
      if (wi == 2) return {8'h0, m_ien};
      if (wi == 3) return {8'h0, m_flag};
      if (wi == 4) return {15'h0, m_fast};
      if (wi >= 8 && wi < 8 + NCH) return m_cap[wi-8];
      return 16'h0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // interrupt lines compared with the model on every clock
   always @(negedge clk) begin
      if (rst_n) chk(irq_o == (m_flag & m_ien), "R7 irq per cycle", irq_o, m_flag & m_ien);
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      tick();
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input string tag, output logic [15:0] v);
      logic [15:0] e;
      tick();
      bus_rd = 1'b1; bus_addr = a;
      #1;
      e = m_read(a);
      v = bus_rdata;
      chk(v == e, tag, v, e);
      tick();
      bus_rd = 1'b0;
   endtask

   logic [15:0] v, c0;

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;

      // R9 / R8: reset values
      foreach (m_cap[i]) begin
         rd(6'(16 + 2*i), "R8 capture reset", v);
         chk(v == 16'h0, "R8 capture reg reset zero", v, 0);
      end
      rd(6'h00, "R9 hold reset", v);  chk(v == 0, "R9 hold zero", v, 0);
      rd(6'h02, "R9 edge reset", v);  chk(v == 0, "R9 edge zero", v, 0);
      rd(6'h06, "R9 flag reset", v);  chk(v == 0, "R9 flag zero", v, 0);
      rd(6'h28, "R9 unmapped", v);    chk(v == 0, "R9 unmapped zero", v, 0);

      // edge codes: ch0 01, ch1 11, ch2 10, ch3 00, ch4 01, ch5 10, ch6 11, ch7 11
      wr(6'h02, 16'hF92D);
      rd(6'h03, "R9 edge readback odd address", v);
      chk(v == 16'hF92D, "R9 edge readback", v, 16'hF92D);
      wr(6'h04, 16'h00FF);

      // R2 latency: pin sampled at edge k, captured at k+2
      tick();
      c0 = cnt_i;
      pin_i[0] = 1'b1;
      repeat (3) tick();
      rd(6'h10, "R2 capture value", v);
      chk(v == c0 + 16'd2, "R2 capture equals counter two edges later", v, c0 + 16'd2);
      rd(6'h06, "R3 flag after capture", v);
      chk(v[0] == 1'b1, "R3 flag set on capture", v, 1);

      // R1: rising edges on 1..7
      tick(); pin_i = 8'hFF;
      repeat (4) tick();
      rd(6'h06, "R1 flags rising", v);
      chk(v == 16'h00D3, "R1 rising-edge selection", v, 16'h00D3);
      wr(6'h06, 16'h00FF);
      rd(6'h06, "R4 clear all", v);
      chk(v == 16'h0, "R4 write ones clears", v, 0);
      tick(); pin_i = 8'h00;
      repeat (4) tick();
      rd(6'h06, "R1 flags falling", v);
      chk(v == 16'h00E6, "R1 falling-edge selection", v, 16'h00E6);

      // R4 partial clear and zero write
      wr(6'h06, 16'h0006);
      rd(6'h06, "R4 partial", v);
      chk(v == 16'h00E0, "R4 partial clear", v, 16'h00E0);
      wr(6'h06, 16'h0000);
      rd(6'h06, "R4 zero write", v);
      chk(v == 16'h00E0, "R4 zero write keeps flags", v, 16'h00E0);

      // R7 enable gating
      wr(6'h04, 16'h0020);
      tick();
      chk(irq_o == 8'h20, "R7 only enabled flag requests", irq_o, 8'h20);
      wr(6'h04, 16'h0000);
      tick();
      chk(irq_o == 8'h00, "R7 all disabled", irq_o, 0);

      // R5 fast clear
      rd(6'h1A, "R5 read cap5 fast off", v);
      rd(6'h06, "R5 flags after plain read", v);
      chk(v == 16'h00E0, "R5 plain read keeps flag", v, 16'h00E0);
      wr(6'h08, 16'h0001);
      rd(6'h1C, "R5 read cap6 fast on", v);
      rd(6'h06, "R5 flags after fast read", v);
      chk(v == 16'h00A0, "R5 fast read clears flag", v, 16'h00A0);
      wr(6'h08, 16'h0000);

      // R6: capture and clear on the same edge (ch1, both edges)
      wr(6'h06, 16'h00FF);
      tick(); pin_i[1] = 1'b1;
      tick();
      tick();
      bus_wr = 1'b1; bus_addr = 6'h06; bus_wdata = 16'h0002;
      tick();
      bus_wr = 1'b0;
      rd(6'h06, "R6 flags", v);
      chk(v[1] == 1'b1, "R6 set wins over clear", v, 16'h0002);

      // R8 hold mode
      wr(6'h00, 16'h0010);
      wr(6'h18, 16'hBEEF);
      rd(6'h18, "R8 held write", v);
      chk(v == 16'hBEEF, "R8 write takes while held", v, 16'hBEEF);
      wr(6'h06, 16'h00FF);
      tick(); pin_i[4] = 1'b1;
      repeat (4) tick();
      rd(6'h18, "R8 held no capture", v);
      chk(v == 16'hBEEF, "R8 no capture while held", v, 16'hBEEF);
      rd(6'h06, "R8 held flag", v);
      chk(v[4] == 1'b0, "R8 no flag while held", v, 0);
      wr(6'h00, 16'h0000);
      wr(6'h18, 16'h1234);
      rd(6'h18, "R8 write in capture mode", v);
      chk(v == 16'hBEEF, "R8 write ignored in capture mode", v, 16'hBEEF);

      // randomized phase against the model
      wr(6'h04, 16'h00FF);
      for (int i = 0; i < 600; i++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 4) begin
            tick(); pin_i = 8'($urandom);
         end else if (op < 7) begin
            rd(6'($urandom_range(0, 47)), "R9 random read vs model", v);
         end else if (op == 7) begin
            wr(6'($urandom_range(0, 47)), 16'($urandom));
         end else begin
            tick();
         end
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule